// File: doc/BRIEF.md
# Stack Pointer and Call/Return Sequencer

This block owns a processor's stack pointer and program counter. It carries out four stack operations: push, pop, call and return. The stack sits in a word-wide memory reached through a request/ready port. The stack grows toward lower addresses. The stack pointer always names the lowest occupied word, which is the top element.

A push or a call first moves the pointer down one word and then stores the word there. A pop or a return first reads the word at the pointer and then moves the pointer up one word. A call stores the address of the next instruction, which is the current program counter plus the instruction length given with the request, and then jumps to the target. A return loads the popped word into the program counter.

Every operation passes through four phases: idle, adjust, memory and done. The memory phase waits for the memory to answer. The done phase raises a single-cycle completion pulse.

Top module: `stack_call_unit`

## Requirements
- R1: While the asynchronous active-low reset is asserted, sp_o equals STACK_TOP, pc_o equals RESET_PC, and busy_o, done_o and mem_req_o are 0.
- R2: Push (op_i = 0): sp_o drops by 4 before the memory phase, and reg_val_i is then written (mem_we_o = 1) at the new sp_o. pc_o is unchanged.
- R3: Pop (op_i = 1): the word at the current sp_o is read and appears on pop_val_o, and sp_o then rises by 4. pc_o is unchanged.
- R4: Call (op_i = 2): sp_o drops by 4 and pc_o + ilen_i is written at the new sp_o. pc_o then takes target_i.
- R5: Return (op_i = 3): the word at the current sp_o is read and loaded into pc_o, and sp_o rises by 4.
- R6: During the memory phase mem_req_o stays high, and mem_addr_o, mem_wdata_o and mem_we_o stay stable, until mem_ready_i is seen high. The address is the stack pointer after the adjust step.
- R7: A request is accepted at a clock edge where req_i = 1 and busy_o = 0. done_o is high for exactly one cycle, 3 + W clock edges after the edge at which req_i was driven, where W is the number of cycles mem_ready_i was held low. busy_o is 0 after done_o.
- R8: A request made while busy_o = 1 is ignored. It changes neither sp_o nor pc_o and produces no memory access or done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| op_i | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| reg_val_i | input | WORD_W | Value to push |
| target_i | input | WORD_W | Call destination |
| ilen_i | input | LEN_W | Length of the call instruction in bytes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pop_val_o | output | WORD_W | Last popped value |
| sp_o | output | WORD_W | Stack pointer |
| pc_o | output | WORD_W | Program counter |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable |
| mem_addr_o | output | WORD_W | Byte address, word aligned |
| mem_wdata_o | output | WORD_W | Write data |
| mem_rdata_i | input | WORD_W | Read data |
| mem_ready_i | input | 1 | Memory completes the access |

## Verification
The bench builds the block with STACK_TOP = 0x108 and RESET_PC = 0x0804854E. With these values a single push lands at 0x104, and a call followed by a return passes through addresses that can be checked by hand. The memory wait is varied from zero to three cycles to exercise the hold behaviour. A request is injected during a busy push to show that it is dropped.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {OP_PUSH = 2'd0, OP_POP = 2'd1, OP_CALL = 2'd2, OP_RET = 2'd3} stk_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ADJ, ST_MEM, ST_DONE} stk_state_e;
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl import stk_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       mem_ready_i,
  output stk_state_e state_o,
  output logic       accept_o,
  output logic       adj_o,
  output logic       fire_o
);
  stk_state_e state_q, state_d;

  assign accept_o = req_i && (state_q == ST_IDLE);
  assign adj_o    = (state_q == ST_ADJ);
  assign fire_o   = (state_q == ST_MEM) && mem_ready_i;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_ADJ;
      ST_ADJ:  state_d = ST_MEM;
      ST_MEM:  if (mem_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned     WORD_W    = 32,
  parameter int unsigned     STEP      = 4,
  parameter logic [WORD_W-1:0] STACK_TOP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_i,
  input  logic              inc_i,
  output logic [WORD_W-1:0] sp_o
);
  localparam logic [WORD_W-1:0] StepW = WORD_W'(STEP);
  logic [WORD_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    sp_q <= STACK_TOP;
    else if (dec_i) sp_q <= sp_q - StepW;
    else if (inc_i) sp_q <= sp_q + StepW;

  assign sp_o = sp_q;
endmodule

// File: rtl/stk_pc.sv
module stk_pc #(
  parameter int unsigned       WORD_W   = 32,
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  output logic [WORD_W-1:0] pc_o
);
  logic [WORD_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pc_q <= RESET_PC;
    else if (load_i) pc_q <= load_val_i;

  assign pc_o = pc_q;
endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit import stk_pkg::*; #(
  parameter int unsigned       WORD_W    = 32,
  parameter int unsigned       LEN_W     = 4,
  parameter logic [WORD_W-1:0] STACK_TOP = 'h1000,
  parameter logic [WORD_W-1:0] RESET_PC  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [WORD_W-1:0] reg_val_i,
  input  logic [WORD_W-1:0] target_i,
  input  logic [LEN_W-1:0]  ilen_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] pop_val_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  stk_state_e        state;
  logic              accept, adj, fire;
  stk_op_e           op_q;
  logic [WORD_W-1:0] payload_q, target_q, pop_q;
  logic              is_wr, pc_load;
  logic [WORD_W-1:0] pc_next;

  stk_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .accept_o    (accept),
    .adj_o       (adj),
    .fire_o      (fire)
  );

  // writers adjust before the access, readers after it
  assign is_wr = (op_q == OP_PUSH) || (op_q == OP_CALL);

  stk_ptr #(.WORD_W(WORD_W), .STEP(WORD_BYTES), .STACK_TOP(STACK_TOP)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (adj && is_wr),
    .inc_i  (fire && !is_wr),
    .sp_o   (sp_o)
  );

  assign pc_load = fire && ((op_q == OP_CALL) || (op_q == OP_RET));
  assign pc_next = (op_q == OP_RET) ? mem_rdata_i : target_q;

  stk_pc #(.WORD_W(WORD_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (pc_load),
    .load_val_i (pc_next),
    .pc_o       (pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      op_q      <= OP_PUSH;
      payload_q <= '0;
      target_q  <= '0;
    end else if (accept) begin
      op_q      <= stk_op_e'(op_i);
      payload_q <= (stk_op_e'(op_i) == OP_CALL) ? pc_o + WORD_W'(ilen_i) : reg_val_i;
      target_q  <= target_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     pop_q <= '0;
    else if (fire && op_q == OP_POP) pop_q <= mem_rdata_i;

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);
  assign mem_req_o   = (state == ST_MEM);
  assign mem_we_o    = mem_req_o && is_wr;
  assign mem_addr_o  = sp_o;
  assign mem_wdata_o = payload_q;
  assign pop_val_o   = pop_q;
endmodule

// File: rtl/stack_call_unit_chk.sv
module stack_call_unit_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] sp_o,
  input logic [WORD_W-1:0] pc_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic [WORD_W-1:0] mem_rdata_i,
  input logic              mem_ready_i,
  input logic [1:0]        op_q,
  input logic [WORD_W-1:0] target_q
);
  p_push_adj_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && mem_we_o |-> sp_o == $past(sp_o) - WORD_W'(4));

  p_pc_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && !op_q[1] |=> $stable(pc_o));

  p_pop_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && !mem_we_o |=> sp_o == $past(sp_o) + WORD_W'(4));

  p_call_pc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && op_q == 2'd2 |=> pc_o == $past(target_q));

  p_ret_pc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && op_q == 2'd3 |=> pc_o == $past(mem_rdata_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_we_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

bind stack_call_unit stack_call_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sp_o        (sp_o),
  .pc_o        (pc_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_ready_i (mem_ready_i),
  .op_q        (op_q),
  .target_q    (target_q)
);

// File: tb/stack_call_unit_tb_top.sv
module stack_call_unit_tb_top;
  localparam logic [31:0] TOP = 32'h0000_0108;
  localparam logic [31:0] RPC = 32'h0804_854E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] val = '0, tgt = '0;
  logic [3:0]  len = '0;
  logic        busy, done, mreq, mwe, mready;
  logic [31:0] popv, sp, pc, maddr, mwdata, mrdata;

  stack_call_unit #(.WORD_W(32), .LEN_W(4), .STACK_TOP(TOP), .RESET_PC(RPC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .reg_val_i(val),
    .target_i(tgt), .ilen_i(len), .busy_o(busy), .done_o(done), .pop_val_o(popv),
    .sp_o(sp), .pc_o(pc), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_ready_i(mready)
  );

  int errors = 0, checks = 0, cyc = 0, lat = 0, wait_cnt = 0, done_cnt = 0, ops = 0;
  logic [31:0] dmem [256];
  logic [31:0] emem [256];
  logic [31:0] msp = TOP, mpc = RPC;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] op; logic [31:0] addr, word, sp, pc, pop; int due;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req_s, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req_s, what, act, expv);
    end
  endtask

  // memory model
  assign mready = mreq && (wait_cnt >= lat);
  assign mrdata = dmem[maddr[9:2]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mreq && mready && mwe) dmem[maddr[9:2]] <= mwdata;
    wait_cnt <= (mreq && !mready) ? wait_cnt + 1 : 0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mreq && mready && exp_q.size() > 0) begin
        chk(maddr == exp_q[0].addr, "R6", "mem address", maddr, exp_q[0].addr);
        chk(mwe == !exp_q[0].op[0], "R6", "write enable", {31'd0, mwe}, {31'd0, !exp_q[0].op[0]});
        if (!exp_q[0].op[0])
          chk(mwdata == exp_q[0].word, exp_q[0].op[1] ? "R4" : "R2", "stored word", mwdata, exp_q[0].word);
      end
      if (mreq && exp_q.size() == 0) chk(1'b0, "R8", "stray access", maddr, '0);
      if (done) begin
        if (exp_q.size() == 0) chk(1'b0, "R8", "stray done", 32'd1, 32'd0);
        else begin
          exp_t e;
          string r;
          e = exp_q.pop_front();
          r = (e.op == 2'd0) ? "R2" : (e.op == 2'd1) ? "R3" : (e.op == 2'd2) ? "R4" : "R5";
          done_cnt++;
          chk(sp == e.sp, r, "stack pointer", sp, e.sp);
          chk(pc == e.pc, r, "program counter", pc, e.pc);
          chk(cyc == e.due, "R7", "done timing", cyc, e.due);
          if (e.op == 2'd1) chk(popv == e.pop, "R3", "popped value", popv, e.pop);
          if (!e.op[0]) chk(dmem[e.addr[9:2]] == e.word, r, "memory word", dmem[e.addr[9:2]], e.word);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] o, input logic [31:0] v, input logic [31:0] t,
                       input logic [3:0] l, input int w, input bit inject);
    exp_t e;
    @(negedge clk);
    lat = w;
    e.op = o; e.word = '0; e.pop = '0;
    case (o)
      2'd0: begin msp -= 4; e.addr = msp; e.word = v; emem[msp[9:2]] = v; end
      2'd1: begin e.addr = msp; e.pop = emem[msp[9:2]]; msp += 4; end
      2'd2: begin msp -= 4; e.addr = msp; e.word = mpc + 32'(l); emem[msp[9:2]] = e.word; mpc = t; end
      default: begin e.addr = msp; mpc = emem[msp[9:2]]; msp += 4; end
    endcase
    e.sp = msp; e.pc = mpc; e.due = cyc + 3 + w;
    exp_q.push_back(e);
    ops++;
    req = 1'b1; op = o; val = v; tgt = t; len = l;
    @(negedge clk);
    req = 1'b0;
    if (inject) begin
      // R8: a pop requested while busy must be dropped
      req = 1'b1; op = 2'd1; val = 32'hBAD0_BAD0;
      @(negedge clk);
      req = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = '0; emem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(sp == TOP, "R1", "reset sp", sp, TOP);
    chk(pc == RPC, "R1", "reset pc", pc, RPC);
    chk({busy, done, mreq} == 3'b000, "R1", "reset flags", {29'd0, busy, done, mreq}, '0);
    rst_n = 1'b1;
    issue(2'd0, 32'hDEAD_BEEF, '0, 4'd0, 0, 1'b0);  // R2: 0x108 -> 0x104
    issue(2'd1, '0, '0, 4'd0, 1, 1'b0);            // R3: back to 0x108
    issue(2'd0, 32'h0000_0011, '0, 4'd0, 2, 1'b0);
    issue(2'd0, 32'h0000_0022, '0, 4'd0, 0, 1'b0);
    issue(2'd1, '0, '0, 4'd0, 3, 1'b0);
    issue(2'd1, '0, '0, 4'd0, 0, 1'b0);
    issue(2'd2, '0, 32'h0804_8B90, 4'd5, 1, 1'b0); // R4: stores 0x08048553
    issue(2'd0, 32'h0000_0055, '0, 4'd0, 2, 1'b1); // R8 injection
    chk(sp == msp, "R8", "sp after ignored request", sp, msp);
    issue(2'd1, '0, '0, 4'd0, 0, 1'b0);
    issue(2'd3, '0, '0, 4'd0, 3, 1'b0);            // R5
    repeat (3) @(negedge clk);
    chk(done_cnt == ops, "R8", "done count", 32'(done_cnt), 32'(ops));
    chk(!busy && sp == TOP, "R7", "idle at top", sp, TOP);
    chk(pc == 32'h0804_8553, "R5", "final pc", pc, 32'h0804_8553);
    wrap_up();
  end

  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 32'(cyc), '0);
    wrap_up();
  end
endmodule